// File: doc/BRIEF.md
# Duty-Cycled Multichannel Sampling Scheduler

This block runs an external eight-bit converter in bursts so that it spends most of its time switched off. It drives the converter's power-down pin low, counts a programmed sleep interval, and then drives the pin high. It then waits a programmed warm-up time, plus an optional extra settle time for a switched reference. After that it scans the enabled channels in ascending order. For each channel it hands one conversion request to a separate interface controller, which handles the bus timing. It passes each returned sample downstream, tagged with its channel number, and switches the converter off again once the final sample of the burst has been taken.

After reset the converter's first result cannot be trusted. The first burst therefore starts with one throw-away conversion on its lowest enabled channel, and that sample is never presented. The channel-enable mask is sampled when the converter wakes, so changes made during a burst apply to the next one. An all-zero mask keeps the converter asleep indefinitely.

Top module: `burst_sampler`

## Requirements
- R1: In the first cycle after reset is released, `pwr_on`, `req_valid` and `res_valid` are all low.
- R2: `req_valid` is never high while `pwr_on` is low. Between bursts with a nonzero mask, `pwr_on` stays low for exactly `cfg_sleep_cycles` cycles, with a minimum of one.
- R3: The first request of a burst rises exactly `max(1, W)` cycles after `pwr_on` rises, where W is `cfg_warm_cycles` plus, when `cfg_refsw_on` is 1, `cfg_refsw_cycles`.
- R4: A burst requests each channel whose bit is set in the mask captured at wake-up, once each, in ascending order. Request code i corresponds to mask bit i, and code 7 is the converter's internal reference channel. Mask changes made after wake-up do not alter the running burst.
- R5: The first burst after reset issues one extra request on its lowest enabled channel ahead of the others. That response is dropped: `res_valid` stays low and the same channel is requested again on the next cycle. No later burst repeats this.
- R6: Each kept response appears on the cycle after `cnv_valid`, with `res_data` equal to `cnv_data` and `res_chan` equal to the requested channel. It stays stable until `res_ready` is high. No new request is issued while a sample is outstanding.
- R7: Once raised, `req_valid` stays high with a stable `req_chan` until `req_ready` is high. It then drops on the next cycle.
- R8: `pwr_on` stays high while the last sample of a burst waits. It goes low in the cycle after that sample is accepted, and at no other time.
- R9: While the mask is all zero, `pwr_on` stays low and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chan_en | input | NCH | Channel enable mask, bit i enables channel code i |
| cfg_sleep_cycles | input | TW | Power-down time between bursts, in cycles |
| cfg_warm_cycles | input | TW | Power-up wait after wake, in cycles |
| cfg_refsw_cycles | input | TW | Extra reference switch-on wait, in cycles |
| cfg_refsw_on | input | 1 | Adds `cfg_refsw_cycles` to the wake wait |
| pwr_on | output | 1 | Power-down pin level, 0 = converter off |
| req_valid | output | 1 | Conversion request to the interface controller |
| req_ready | input | 1 | Interface controller accepts the request |
| req_chan | output | log2(NCH) | Channel code of the request |
| cnv_valid | input | 1 | One-cycle pulse carrying a conversion result |
| cnv_data | input | DW | Conversion result |
| res_valid | output | 1 | Tagged sample available |
| res_ready | input | 1 | Downstream accepts the sample |
| res_chan | output | log2(NCH) | Channel tag of the sample |
| res_data | output | DW | Sample value |

## Verification
The assertions take three things for granted about the inputs. The configuration fields that set the timing stay constant from wake-up until the burst ends. `cnv_valid` pulses only once per accepted request, after the request has been handed over. The warm-up check also relies on the configuration not changing during the wake wait. The bench writes new timing values only in the cycle in which the final sample of a burst is accepted. It scrambles only the mask while a burst is running, and it returns exactly one response per request after a random delay.

// File: rtl/bsched_pkg.sv
// Shared types for the burst sampling scheduler.
package bsched_pkg;
    // Scheduler phases: converter off, warming up, request out,
    // waiting for a result, result offered downstream.
    typedef enum logic [2:0] {
        PH_SLEEP = 3'd0,
        PH_WAKE  = 3'd1,
        PH_ISSUE = 3'd2,
        PH_WAIT  = 3'd3,
        PH_SHOW  = 3'd4
    } phase_t;
endpackage

// File: rtl/bsched_timer.sv
// Phase timer: counts cycles while run is high and restarts at zero
// whenever run is low. done is high in the cycle in which the phase has
// lasted max(1, limit) cycles. Assumes limit is steady while run is high.
module bsched_timer #(
    parameter int LW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [LW-1:0] limit,
    output logic          done
);
    logic [LW-1:0] cnt;

    // Saturating count of cycles spent in the timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare elapsed+1 against the limit, widened so nothing wraps.
    always_comb begin
        done = (({1'b0, cnt} + {{LW{1'b0}}, 1'b1}) >= {1'b0, limit});
    end
endmodule

// File: rtl/bsched_pick.sv
// Channel picker: returns the lowest enabled channel at or above base
// (incl=1) or strictly above base (incl=0). Assumes NCH is a power of two.
module bsched_pick #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  base,
    input  logic           incl,
    output logic           found,
    output logic [CW-1:0]  idx
);
    logic [NCH-1:0] elig;

    for (genvar g = 0; g < NCH; g++) begin : g_elig
        localparam logic [CW-1:0] GI = CW'(g);
        // Channel g qualifies when enabled and positioned after the base.
        always_comb begin
            elig[g] = mask[g] && ((GI > base) || (incl && (GI == base)));
        end
    end

    // Lowest-index priority encode over the qualifying channels.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/bsched_hold.sv
// Result holding register: captures a tagged sample on load and offers
// it until drop. Assumes load and drop never coincide.
module bsched_hold #(
    parameter int CW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] in_chan,
    input  logic [DW-1:0] in_data,
    input  logic          drop,
    output logic          out_valid,
    output logic [CW-1:0] out_chan,
    output logic [DW-1:0] out_data
);
    // Valid flag: set by a capture, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (drop) begin
            out_valid <= 1'b0;
        end
    end

    // Payload capture; held unchanged while offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_chan <= '0;
            out_data <= '0;
        end else if (load) begin
            out_chan <= in_chan;
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/burst_sampler.sv
// Burst sampling scheduler. It keeps the converter powered down for
// cfg_sleep_cycles, wakes it, and waits the warm-up time (plus the
// reference switch time if enabled). It then requests every enabled
// channel in ascending order, one at a time, and powers down after the
// last sample is accepted. The first burst after reset begins with a
// discarded conversion. Assumes timing fields stay steady during a burst
// and that one cnv_valid pulse follows each accepted request.
module burst_sampler #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int TW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           cfg_chan_en,
    input  logic [TW-1:0]            cfg_sleep_cycles,
    input  logic [TW-1:0]            cfg_warm_cycles,
    input  logic [TW-1:0]            cfg_refsw_cycles,
    input  logic                     cfg_refsw_on,
    output logic                     pwr_on,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [$clog2(NCH)-1:0]   req_chan,
    input  logic                     cnv_valid,
    input  logic [DW-1:0]            cnv_data,
    output logic                     res_valid,
    input  logic                     res_ready,
    output logic [$clog2(NCH)-1:0]   res_chan,
    output logic [DW-1:0]            res_data
);
    import bsched_pkg::*;

    localparam int CW = $clog2(NCH);
    localparam int LW = TW + 1;

    phase_t         phase, phase_nx;
    logic [NCH-1:0] burst_mask, burst_mask_nx;
    logic [CW-1:0]  cur_chan, cur_chan_nx;
    logic           dummy_pend, dummy_pend_nx;

    logic           sleep_done, warm_done;
    logic [LW-1:0]  sleep_lim, warm_lim;
    logic           pick_found;
    logic [CW-1:0]  pick_idx, pick_base;
    logic           pick_incl;
    logic           hold_load, hold_drop;

    // Timer limits; the reference switch time adds to warm-up when enabled.
    always_comb begin
        sleep_lim = {1'b0, cfg_sleep_cycles};
        warm_lim  = {1'b0, cfg_warm_cycles}
                  + (cfg_refsw_on ? {1'b0, cfg_refsw_cycles} : {LW{1'b0}});
    end

    bsched_timer #(.LW(LW)) u_sleep_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_SLEEP),
        .limit (sleep_lim),
        .done  (sleep_done)
    );

    bsched_timer #(.LW(LW)) u_warm_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_WAKE),
        .limit (warm_lim),
        .done  (warm_done)
    );

    // Picker search: from channel 0 at burst start, otherwise past current.
    always_comb begin
        pick_incl = (phase == PH_WAKE);
        pick_base = (phase == PH_WAKE) ? '0 : cur_chan;
    end

    bsched_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .mask  (burst_mask),
        .base  (pick_base),
        .incl  (pick_incl),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Kept results load the holding register; acceptance drains it.
    always_comb begin
        hold_load = (phase == PH_WAIT) && cnv_valid && !dummy_pend;
        hold_drop = (phase == PH_SHOW) && res_ready;
    end

    bsched_hold #(.CW(CW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_load),
        .in_chan   (cur_chan),
        .in_data   (cnv_data),
        .drop      (hold_drop),
        .out_valid (res_valid),
        .out_chan  (res_chan),
        .out_data  (res_data)
    );

    // Next-state logic of the burst sequencer.
    always_comb begin
        phase_nx      = phase;
        burst_mask_nx = burst_mask;
        cur_chan_nx   = cur_chan;
        dummy_pend_nx = dummy_pend;
        unique case (phase)
            PH_SLEEP: begin
                if (sleep_done && (cfg_chan_en != '0)) begin
                    phase_nx      = PH_WAKE;
                    burst_mask_nx = cfg_chan_en;
                end
            end
            PH_WAKE: begin
                if (warm_done) begin
                    phase_nx    = pick_found ? PH_ISSUE : PH_SLEEP;
                    cur_chan_nx = pick_idx;
                end
            end
            PH_ISSUE: begin
                if (req_ready) begin
                    phase_nx = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (cnv_valid) begin
                    if (dummy_pend) begin
                        dummy_pend_nx = 1'b0;
                        phase_nx      = PH_ISSUE;
                    end else begin
                        phase_nx = PH_SHOW;
                    end
                end
            end
            PH_SHOW: begin
                if (res_ready) begin
                    phase_nx    = pick_found ? PH_ISSUE : PH_SLEEP;
                    cur_chan_nx = pick_found ? pick_idx : cur_chan;
                end
            end
            default: phase_nx = PH_SLEEP;
        endcase
    end

    // Sequencer state registers; the discard flag is armed by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_SLEEP;
            burst_mask <= '0;
            cur_chan   <= '0;
            dummy_pend <= 1'b1;
        end else begin
            phase      <= phase_nx;
            burst_mask <= burst_mask_nx;
            cur_chan   <= cur_chan_nx;
            dummy_pend <= dummy_pend_nx;
        end
    end

    // Pin and request outputs decoded from the phase register.
    always_comb begin
        pwr_on    = (phase != PH_SLEEP);
        req_valid = (phase == PH_ISSUE);
        req_chan  = cur_chan;
    end
endmodule

// File: rtl/bsched_chk.sv
// Property checker for burst_sampler, attached by bind below. Assumes
// timing configuration is steady from wake-up to the first request.
module bsched_chk #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int TW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         cfg_chan_en,
    input logic [TW-1:0]          cfg_warm_cycles,
    input logic [TW-1:0]          cfg_refsw_cycles,
    input logic                   cfg_refsw_on,
    input logic                   pwr_on,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [$clog2(NCH)-1:0] req_chan,
    input logic                   res_valid,
    input logic                   res_ready,
    input logic [$clog2(NCH)-1:0] res_chan,
    input logic [DW-1:0]          res_data
);
    logic [TW+1:0] up_cnt;
    logic [TW+1:0] warm_total;

    // Cycles since the power-down pin went high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            up_cnt <= '0;
        end else if (up_cnt != '1) begin
            up_cnt <= up_cnt + 1'b1;
        end
    end

    // Required wait before any request, from the configuration inputs.
    always_comb begin
        warm_total = {2'b00, cfg_warm_cycles}
                   + (cfg_refsw_on ? {2'b00, cfg_refsw_cycles} : '0);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pwr_on && !req_valid && !res_valid));

    // R2
    sleep_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !req_valid);

    // R3
    warm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (up_cnt >= warm_total));

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_chan) && $stable(res_data)));

    // R6
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_valid);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_chan)));

    // R8
    pd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> $past(res_valid && res_ready));

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && (cfg_chan_en == '0)) |=> !pwr_on);
endmodule

bind burst_sampler bsched_chk #(.NCH(NCH), .DW(DW), .TW(TW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_chan_en      (cfg_chan_en),
    .cfg_warm_cycles  (cfg_warm_cycles),
    .cfg_refsw_cycles (cfg_refsw_cycles),
    .cfg_refsw_on     (cfg_refsw_on),
    .pwr_on           (pwr_on),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_chan         (req_chan),
    .res_valid        (res_valid),
    .res_ready        (res_ready),
    .res_chan         (res_chan),
    .res_data         (res_data)
);

// File: tb/sim_burst_sampler.sv
module sim_burst_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_chan_en = '0;
    logic [15:0] cfg_sleep_cycles = '0;
    logic [15:0] cfg_warm_cycles = '0;
    logic [15:0] cfg_refsw_cycles = '0;
    logic        cfg_refsw_on = 1'b0;
    logic        pwr_on, req_valid, res_valid;
    logic        req_ready = 1'b0;
    logic        cnv_valid = 1'b0;
    logic        res_ready = 1'b0;
    logic [7:0]  cnv_data = '0;
    logic [2:0]  req_chan, res_chan;
    logic [7:0]  res_data;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    logic [7:0] m_a [NB+1];
    int iv_a [NB+1];
    int wm_a [NB+1];
    int rs_a [NB+1];
    bit re_a [NB+1];
    int nxt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_sampler u0 (
        .clk(clk), .rst_n(rst_n), .cfg_chan_en(cfg_chan_en),
        .cfg_sleep_cycles(cfg_sleep_cycles), .cfg_warm_cycles(cfg_warm_cycles),
        .cfg_refsw_cycles(cfg_refsw_cycles), .cfg_refsw_on(cfg_refsw_on),
        .pwr_on(pwr_on), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .cnv_valid(cnv_valid), .cnv_data(cnv_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
        .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input int k);
        cfg_chan_en      = m_a[k];
        cfg_sleep_cycles = 16'(iv_a[k]);
        cfg_warm_cycles  = 16'(wm_a[k]);
        cfg_refsw_cycles = 16'(rs_a[k]);
        cfg_refsw_on     = re_a[k];
    endtask

    function automatic int wake_wait(input int k);
        int t = wm_a[k] + (re_a[k] ? rs_a[k] : 0);
        return (t < 1) ? 1 : t;
    endfunction

    // Serve one request as the interface controller; entered at the
    // negedge where the request is expected to be up.
    task automatic serve(input int ch, input bit dummy, input bit last);
        int d;
        logic [7:0] v;
        chk(req_valid && req_chan == 3'(ch), "R4 request channel", int'(req_chan), ch);
        d = $urandom % 3;
        repeat (d) begin
            @(negedge clk);
            chk(req_valid && req_chan == 3'(ch), "R7 request held", int'(req_valid), 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid, "R7 request dropped after accept", int'(req_valid), 0);
        d = $urandom % 4;
        repeat (d) @(negedge clk);
        v = 8'($urandom);
        cnv_valid = 1'b1;
        cnv_data = v;
        @(negedge clk);
        cnv_valid = 1'b0;
        if (dummy) begin
            chk(!res_valid, "R5 discarded result hidden", int'(res_valid), 0);
            chk(req_valid && req_chan == 3'(ch), "R5 same channel reissued", int'(req_chan), ch);
            return;
        end
        chk(res_valid && res_chan == 3'(ch), "R6 result channel tag", int'(res_chan), ch);
        chk(res_data == v, "R6 result data", int'(res_data), int'(v));
        d = $urandom % 3;
        repeat (d) begin
            @(negedge clk);
            chk(res_valid && res_data == v && pwr_on && !req_valid,
                "R8 held sample keeps power on", int'(pwr_on), 1);
        end
        res_ready = 1'b1;
        if (last) apply_cfg(nxt);
        @(negedge clk);
        res_ready = 1'b0;
        if (last) chk(!pwr_on, "R8 power down after last accept", int'(pwr_on), 0);
    endtask

    task automatic burst(input int k, input bit first, input bit chk_sleep);
        int cnt = 0;
        int lo = -1;
        int hi = -1;
        logic [7:0] m;
        while (!pwr_on) begin
            if (req_valid) chk(0, "R2 request while off", 1, 0);
            cnt++;
            @(negedge clk);
        end
        if (chk_sleep) chk(cnt == iv_a[k], "R2 sleep length", cnt, iv_a[k]);
        cnt = 0;
        while (pwr_on && !req_valid) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == wake_wait(k), "R3 warm-up wait", cnt, wake_wait(k));
        m = m_a[k];
        cfg_chan_en = 8'($urandom) | 8'h01;  // R4: mid-burst change ignored
        for (int i = 0; i < 8; i++) if (m[i]) begin
            if (lo < 0) lo = i;
            hi = i;
        end
        if (first) serve(lo, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) if (m[i]) serve(i, 1'b0, i == hi);
    endtask

    initial begin
        void'($urandom(32'd4711));
        m_a[0] = 8'b1010_0110; iv_a[0] = 5; wm_a[0] = 3; rs_a[0] = 2; re_a[0] = 1;
        m_a[1] = 8'h80; iv_a[1] = 1; wm_a[1] = 0; rs_a[1] = 7; re_a[1] = 0;
        m_a[2] = 8'hFF; iv_a[2] = 4; wm_a[2] = 6; rs_a[2] = 0; re_a[2] = 1;
        m_a[3] = 8'h01; iv_a[3] = 2; wm_a[3] = 0; rs_a[3] = 0; re_a[3] = 1;
        for (int k = 4; k < NB; k++) begin
            m_a[k] = 8'($urandom);
            if (m_a[k] == 0) m_a[k] = 8'h41;
            iv_a[k] = 1 + ($urandom % 20);
            wm_a[k] = $urandom % 16;
            rs_a[k] = $urandom % 11;
            re_a[k] = 1'($urandom);
        end
        m_a[NB] = 8'h00; iv_a[NB] = 3; wm_a[NB] = 2; rs_a[NB] = 1; re_a[NB] = 1;
        apply_cfg(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!pwr_on && !req_valid && !res_valid, "R1 reset state", int'(pwr_on), 0);
        for (int k = 0; k < NB; k++) begin
            nxt = k + 1;
            burst(k, k == 0, k != 0);
        end
        // R9: empty mask keeps the converter off
        begin
            bit quiet = 1;
            repeat (200) begin
                @(negedge clk);
                if (pwr_on || req_valid) quiet = 0;
            end
            chk(quiet, "R9 empty mask stays asleep", int'(quiet), 1);
        end
        m_a[NB] = 8'h24;
        cfg_chan_en = 8'h24;
        burst(NB, 1'b0, 1'b0);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule